// File: doc/BRIEF.md
# Branch Trace History Buffer

The block keeps a short history of taken control transfers for a debugger. Each time the core retires a branch it presents the branch's source PC, target PC, a class code and two qualifier flags. Transfers that pass a per-class filter are written into an eight-slot circular store. A debugger reads the store through an index port on which index 0 is the most recent record. The block also reports how many slots hold valid data and whether the store is full.

Two kinds of branch are never kept. The first is a conditional branch whose displacement is zero. The second is the jump to the reset vector that a reset causes. In the default wrapping mode, a new record replaces the oldest one once all eight slots are in use.

A continuous mode lets a debugger gather a longer history. When the store fills, the block asserts a stall toward the core and holds its contents until the debugger acknowledges that it has read them. The acknowledge empties the store and capture resumes. This hand-off is granted at most four times. After that, the store wraps as it does in the default mode.

Top module: `branch_trace_buf`

## Requirements
- R1: A branch that passes the filter is stored one cycle after its retire strobe, and `valid_cnt` rises by one. Reading `rd_idx` = k returns the source and target of the k-th most recent stored branch (k = 0 is the newest).
- R2: The `br_kind` codes are 0 = plain branch, 1 = subroutine call or return, 2 = exception or interrupt entry or exception return, and 3 = reserved. Bit i of `kind_en` enables kind i. A disabled kind and the reserved code are never stored.
- R3: A retire with `br_cond` = 1 and `disp_zero` = 1 is never stored. `disp_zero` has no effect when `br_cond` = 0.
- R4: A retire with `reset_br` = 1 is never stored.
- R5: `valid_cnt` saturates at 8. In wrapping mode a ninth stored branch replaces the oldest record, and `buf_full` is 1 exactly when `valid_cnt` is 8.
- R6: In continuous mode, the branch that fills the eighth slot makes `core_stall` and `buf_full` read 1 on the next cycle. While stalled, retire strobes store nothing.
- R7: `drain_ack` while stalled empties the store and drops `core_stall` on the next cycle. Each stall raises `handoff_cnt` by one. `drain_ack` while not stalled has no effect.
- R8: At most four hand-offs happen. Once `handoff_cnt` is 4, continuous mode wraps like the default mode and never stalls.
- R9: `clr` empties the store, clears `handoff_cnt` and releases `core_stall` on the next cycle.
- R10: For `rd_idx` >= `valid_cnt`, `rd_valid` is 0 and `rd_src` and `rd_dst` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous empty of store and hand-off count |
| retire_vld | input | 1 | A branch retires this cycle |
| src_pc | input | 32 | Address of the branch instruction |
| dst_pc | input | 32 | Address the branch went to |
| br_kind | input | 2 | Branch class code |
| br_cond | input | 1 | Branch is conditional |
| disp_zero | input | 1 | Branch displacement is zero |
| reset_br | input | 1 | Transfer is the reset-vector jump |
| kind_en | input | 3 | Per-class capture enables |
| cont_mode | input | 1 | Continuous hand-off mode |
| drain_ack | input | 1 | Debugger has read the full store |
| rd_idx | input | 3 | Read index, 0 = newest |
| rd_src | output | 32 | Source address at `rd_idx` |
| rd_dst | output | 32 | Target address at `rd_idx` |
| rd_valid | output | 1 | `rd_idx` addresses a stored record |
| valid_cnt | output | 4 | Number of stored records |
| buf_full | output | 1 | All eight slots hold records |
| core_stall | output | 1 | Core held for a hand-off |
| handoff_cnt | output | 3 | Hand-offs granted since clear |

## Verification
The bench drives branches past the write pointer's wrap so that the newest-first ordering is checked across the ring seam. A design with an off-by-one in its read index would return a neighbouring record there. The bench sends each excluded branch, one per filter rule, beside an admitted branch that differs from it in only one flag. A filter that ignores a qualifier, or swaps enable bits, then shows a wrong count or a wrong record. The bench also drives a retire strobe during a stall, a fifth fill in continuous mode and a stray acknowledge outside a stall. A design that keeps capturing while stalled, lets a fifth hand-off through, or empties on a stray acknowledge shows a wrong count, stall or hand-off value at the ports.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int NUM_KINDS = 3;

  typedef enum logic [1:0] {
    KIND_PLAIN   = 2'd0,
    KIND_CALLRET = 2'd1,
    KIND_EXCEPT  = 2'd2,
    KIND_RSVD    = 2'd3
  } br_kind_e;

  // True when the class code names a real class whose enable bit is set.
  function automatic logic kind_allowed(br_kind_e k, logic [NUM_KINDS-1:0] en);
    logic ok;
    ok = 1'b0;
    for (int i = 0; i < NUM_KINDS; i++) begin
      if (k == br_kind_e'(i)) ok = en[i];
    end
    return ok;
  endfunction

  // Only a conditional branch with zero displacement is excluded.
  function automatic logic self_loop_skip(logic cond, logic dz);
    return cond & dz;
  endfunction
endpackage

// File: rtl/btb_filter.sv
module btb_filter
  import btb_pkg::*;
(
  input  logic                 retire_vld,
  input  logic [1:0]           br_kind,
  input  logic                 br_cond,
  input  logic                 disp_zero,
  input  logic                 reset_br,
  input  logic [NUM_KINDS-1:0] kind_en,
  input  logic                 hold,
  output logic                 accept
);
  logic kind_ok;
  logic skip_loop;

  always_comb begin
    kind_ok   = kind_allowed(br_kind_e'(br_kind), kind_en);
    skip_loop = self_loop_skip(br_cond, disp_zero);
    accept    = retire_vld & kind_ok & ~skip_loop & ~reset_br & ~hold;
  end
endmodule

// File: rtl/btb_ctrl.sv
module btb_ctrl #(
  parameter int DEPTH       = 8,
  parameter int MAX_HANDOFF = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int HW = $clog2(MAX_HANDOFF + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          accept,
  input  logic          cont_mode,
  input  logic          drain_ack,
  output logic [PW-1:0] wr_ptr,
  output logic [CW-1:0] count,
  output logic          stall,
  output logic [HW-1:0] handoffs,
  output logic          handoff_evt,
  output logic          drain_evt
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] LAST_CNT = CW'(DEPTH - 1);
  localparam logic [HW-1:0] HO_MAX   = HW'(MAX_HANDOFF);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    handoff_evt = accept & cont_mode & (count == LAST_CNT) & (handoffs < HO_MAX);
    drain_evt   = stall & drain_ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      count    <= '0;
      stall    <= 1'b0;
      handoffs <= '0;
    end else if (clr) begin
      wr_ptr   <= '0;
      count    <= '0;
      stall    <= 1'b0;
      handoffs <= '0;
    end else if (drain_evt) begin
      wr_ptr <= '0;
      count  <= '0;
      stall  <= 1'b0;
    end else if (accept) begin
      wr_ptr <= ptr_inc(wr_ptr);
      if (count != FULL_CNT) count <= count + 1'b1;
      if (handoff_evt) begin
        stall    <= 1'b1;
        handoffs <= handoffs + 1'b1;
      end
    end
  end
endmodule

// File: rtl/btb_store.sv
module btb_store #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_ptr,
  input  logic [AW-1:0] wr_src,
  input  logic [AW-1:0] wr_dst,
  input  logic [CW-1:0] count,
  input  logic [PW-1:0] rd_idx,
  output logic          rd_valid,
  output logic [AW-1:0] rd_src,
  output logic [AW-1:0] rd_dst
);
  logic [AW-1:0] src_q [DEPTH];
  logic [AW-1:0] dst_q [DEPTH];
  logic [PW-1:0] rd_slot;

  // Slot holding the record that is 'age' steps older than the newest.
  function automatic logic [PW-1:0] slot_of(logic [PW-1:0] wp, logic [PW-1:0] age);
    int s;
    s = int'(wp) - 1 - int'(age);
    if (s < 0) s = s + DEPTH;
    return PW'(s);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
      end else if (wr_en && (wr_ptr == PW'(i))) begin
        src_q[i] <= wr_src;
        dst_q[i] <= wr_dst;
      end
    end
  end

  always_comb begin
    rd_slot  = slot_of(wr_ptr, rd_idx);
    rd_valid = CW'(rd_idx) < count;
    rd_src   = rd_valid ? src_q[rd_slot] : '0;
    rd_dst   = rd_valid ? dst_q[rd_slot] : '0;
  end
endmodule

// File: rtl/branch_trace_buf.sv
module branch_trace_buf #(
  parameter int AW          = 32,
  parameter int DEPTH       = 8,
  parameter int MAX_HANDOFF = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int HW = $clog2(MAX_HANDOFF + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          retire_vld,
  input  logic [AW-1:0] src_pc,
  input  logic [AW-1:0] dst_pc,
  input  logic [1:0]    br_kind,
  input  logic          br_cond,
  input  logic          disp_zero,
  input  logic          reset_br,
  input  logic [2:0]    kind_en,
  input  logic          cont_mode,
  input  logic          drain_ack,
  input  logic [PW-1:0] rd_idx,
  output logic [AW-1:0] rd_src,
  output logic [AW-1:0] rd_dst,
  output logic          rd_valid,
  output logic [CW-1:0] valid_cnt,
  output logic          buf_full,
  output logic          core_stall,
  output logic [HW-1:0] handoff_cnt
);
  logic          accept_w;
  logic          handoff_evt_w;
  logic          drain_evt_w;
  logic [PW-1:0] wr_ptr_w;

  btb_filter u_filter (
    .retire_vld (retire_vld),
    .br_kind    (br_kind),
    .br_cond    (br_cond),
    .disp_zero  (disp_zero),
    .reset_br   (reset_br),
    .kind_en    (kind_en),
    .hold       (core_stall),
    .accept     (accept_w)
  );

  btb_ctrl #(.DEPTH(DEPTH), .MAX_HANDOFF(MAX_HANDOFF)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .accept      (accept_w),
    .cont_mode   (cont_mode),
    .drain_ack   (drain_ack),
    .wr_ptr      (wr_ptr_w),
    .count       (valid_cnt),
    .stall       (core_stall),
    .handoffs    (handoff_cnt),
    .handoff_evt (handoff_evt_w),
    .drain_evt   (drain_evt_w)
  );

  btb_store #(.AW(AW), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (accept_w & ~clr & ~drain_evt_w),
    .wr_ptr   (wr_ptr_w),
    .wr_src   (src_pc),
    .wr_dst   (dst_pc),
    .count    (valid_cnt),
    .rd_idx   (rd_idx),
    .rd_valid (rd_valid),
    .rd_src   (rd_src),
    .rd_dst   (rd_dst)
  );

  assign buf_full = (valid_cnt == CW'(DEPTH));
endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
  parameter int AW          = 32,
  parameter int DEPTH       = 8,
  parameter int MAX_HANDOFF = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int HW = $clog2(MAX_HANDOFF + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          accept,
  input logic          handoff_evt,
  input logic          drain_ack,
  input logic          stall,
  input logic          full,
  input logic [CW-1:0] valid_cnt,
  input logic [HW-1:0] handoff_cnt,
  input logic          rd_valid,
  input logic [AW-1:0] rd_src,
  input logic [AW-1:0] rd_dst
);
  // R1: an admitted branch grows a non-full store by one
  p_grow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !clr && (valid_cnt < CW'(DEPTH)) |=> valid_cnt == $past(valid_cnt) + 1'b1);

  // R2, R3, R4: a branch the filter rejects leaves the store unchanged
  p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept && !clr && !(stall && drain_ack) |=> $stable(valid_cnt));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_cnt <= CW'(DEPTH));

  p_stall_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> full);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !drain_ack && !clr |=> stall && $stable(valid_cnt));

  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall && drain_ack && !clr |=> (valid_cnt == '0) && !stall);

  p_handoff_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    handoff_evt && !clr |=> stall && (handoff_cnt == $past(handoff_cnt) + 1'b1));

  p_handoff_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    handoff_cnt <= HW'(MAX_HANDOFF));

  p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (valid_cnt == '0) && (handoff_cnt == '0) && !stall);

  p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_src == '0) && (rd_dst == '0));
endmodule

bind branch_trace_buf btb_chk #(.AW(AW), .DEPTH(DEPTH), .MAX_HANDOFF(MAX_HANDOFF)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr         (clr),
  .accept      (accept_w),
  .handoff_evt (handoff_evt_w),
  .drain_ack   (drain_ack),
  .stall       (core_stall),
  .full        (buf_full),
  .valid_cnt   (valid_cnt),
  .handoff_cnt (handoff_cnt),
  .rd_valid    (rd_valid),
  .rd_src      (rd_src),
  .rd_dst      (rd_dst)
);

// File: tb/branch_trace_buf_tb.sv
module branch_trace_buf_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        retire_vld = 1'b0;
  logic [31:0] src_pc = '0;
  logic [31:0] dst_pc = '0;
  logic [1:0]  br_kind = '0;
  logic        br_cond = 1'b0;
  logic        disp_zero = 1'b0;
  logic        reset_br = 1'b0;
  logic [2:0]  kind_en = 3'b111;
  logic        cont_mode = 1'b0;
  logic        drain_ack = 1'b0;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_src, rd_dst;
  logic        rd_valid;
  logic [3:0]  valid_cnt;
  logic        buf_full, core_stall;
  logic [2:0]  handoff_cnt;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // scoreboard: expected records, newest at the front
  logic [63:0] exp_q[$];
  bit          m_stall = 0;
  int          m_ho = 0;

  always #4 clk = ~clk;

  branch_trace_buf u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .retire_vld(retire_vld),
    .src_pc(src_pc), .dst_pc(dst_pc), .br_kind(br_kind), .br_cond(br_cond),
    .disp_zero(disp_zero), .reset_br(reset_br), .kind_en(kind_en),
    .cont_mode(cont_mode), .drain_ack(drain_ack), .rd_idx(rd_idx),
    .rd_src(rd_src), .rd_dst(rd_dst), .rd_valid(rd_valid),
    .valid_cnt(valid_cnt), .buf_full(buf_full), .core_stall(core_stall),
    .handoff_cnt(handoff_cnt)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: presents one retire and pushes the expected record if admitted
  task automatic send(logic [1:0] k, logic [31:0] s, logic [31:0] d,
                      logic c, logic dz, logic rb);
    bit take;
    @(negedge clk);
    retire_vld = 1'b1; br_kind = k; src_pc = s; dst_pc = d;
    br_cond = c; disp_zero = dz; reset_br = rb;
    take = (k != 2'd3) && kind_en[k] && !(c && dz) && !rb && !m_stall;
    if (take) begin
      exp_q.push_front({s, d});
      if (exp_q.size() > 8) void'(exp_q.pop_back());
      if (cont_mode && exp_q.size() == 8 && m_ho < 4) begin
        m_stall = 1; m_ho++;
      end
    end
    @(negedge clk);
    retire_vld = 1'b0; br_cond = 1'b0; disp_zero = 1'b0; reset_br = 1'b0;
  endtask

  task automatic plain(logic [31:0] s);
    send(2'd0, s, s + 32'h100, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic drain();
    @(negedge clk);
    drain_ack = 1'b1;
    if (m_stall) begin
      exp_q.delete(); m_stall = 0;
    end
    @(negedge clk);
    drain_ack = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk);
    clr = 1'b1;
    exp_q.delete(); m_stall = 0; m_ho = 0;
    @(negedge clk);
    clr = 1'b0;
  endtask

  // monitor: pops the expected records and compares every read index
  task automatic check_all(string req);
    logic [63:0] q[$];
    q = exp_q;
    check({req, " count"}, 64'(valid_cnt), 64'(exp_q.size()));
    check({req, "/R5 full"}, 64'(buf_full), 64'(exp_q.size() == 8));
    check({req, "/R6 stall"}, 64'(core_stall), 64'(m_stall));
    check({req, "/R7 handoffs"}, 64'(handoff_cnt), 64'(m_ho));
    for (int i = 0; i < 8; i++) begin
      logic [63:0] e;
      rd_idx = 3'(i);
      #0.5;
      if (q.size() > 0) begin
        e = q.pop_front();
        check({req, "/R1 rd_valid"}, 64'(rd_valid), 64'd1);
        check({req, "/R1 record"}, {rd_src, rd_dst}, e);
      end else begin
        check({req, "/R10 rd_valid"}, 64'(rd_valid), 64'd0);
        check({req, "/R10 data"}, {rd_src, rd_dst}, 64'd0);
      end
    end
    rd_idx = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R9 reset");

    // R1: basic newest-first order
    plain(32'h1000); plain(32'h2000);
    send(2'd1, 32'h3000, 32'h3400, 1'b0, 1'b0, 1'b0);
    check_all("R1 three");

    // R2: class enables and reserved code
    kind_en = 3'b101;
    send(2'd1, 32'h4000, 32'h4100, 1'b0, 1'b0, 1'b0);
    send(2'd3, 32'h4200, 32'h4300, 1'b0, 1'b0, 1'b0);
    send(2'd2, 32'h4400, 32'h4500, 1'b0, 1'b0, 1'b0);
    kind_en = 3'b110;
    send(2'd0, 32'h4600, 32'h4700, 1'b0, 1'b0, 1'b0);
    kind_en = 3'b111;
    check_all("R2 filter");

    // R3: zero-displacement conditional skipped, qualifiers alone admitted
    send(2'd0, 32'h5000, 32'h5004, 1'b1, 1'b1, 1'b0);
    send(2'd0, 32'h5100, 32'h5180, 1'b1, 1'b0, 1'b0);
    send(2'd0, 32'h5200, 32'h5204, 1'b0, 1'b1, 1'b0);
    check_all("R3 dz");

    // R4: reset-vector jump skipped
    send(2'd2, 32'h6000, 32'hA000_0000, 1'b0, 1'b0, 1'b1);
    check_all("R4 reset_br");

    // R5: overflow wraps, oldest replaced
    for (int i = 0; i < 7; i++) plain(32'h7000 + 32'(i) * 32'h10);
    check_all("R5 wrap");

    // R7: stray acknowledge has no effect
    drain();
    check_all("R7 stray ack");

    // R9: clear
    do_clr();
    check_all("R9 clear");

    // R6/R7/R8: continuous hand-offs
    cont_mode = 1'b1;
    for (int h = 0; h < 4; h++) begin
      for (int i = 0; i < 8; i++) plain(32'h8000 + 32'(h) * 32'h1000 + 32'(i) * 32'h8);
      check_all("R6 stall");
      plain(32'h9999_0000);
      check_all("R6 ignored while stalled");
      drain();
      check_all("R7 drained");
    end
    for (int i = 0; i < 11; i++) plain(32'hC000 + 32'(i) * 32'h4);
    check_all("R8 no fifth handoff");

    // R9: clear restores hand-offs
    do_clr();
    for (int i = 0; i < 8; i++) plain(32'hD000 + 32'(i) * 32'h4);
    check_all("R9 handoff after clear");
    drain();
    check_all("R9 drained after clear");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule